// File: doc/BRIEF.md
# DMT Symbol Timebase with Sample Slip

This block keeps the real-time counters of one direction of a multicarrier modem. A sample counter runs through the samples of one symbol. A symbol counter runs through the symbols of one superframe. A sync counter runs through the superframes of one hyperframe. Each time one of these counters rolls over, the block raises a one-cycle boundary strobe for the schedulers downstream. The transmit side and the receive side each use their own instance, and the two instances share no state.

All three lengths come from configuration inputs. Nominal operation uses 544 samples per symbol, which is 512 data samples plus a 32-sample cyclic prefix, and 68 symbols per superframe. Timing recovery has two one-cycle request inputs. One stretches the current symbol by a single sample and the other shortens it by a single sample. This lets a frequency offset too large for phase rotation be absorbed in the time domain. The block accepts at most one such request per symbol.

A synchronous load input forces all three counters to programmed values. This lets the timebase realign to a frame boundary found by the receiver.

Top module: `dmt_symbol_timebase`

## Requirements
- R1: While reset is high and on the cycle after reset is released, the sample, symbol and sync counters read 0 and no strobe is high. Reset is synchronous and active high, and the lengths are at least 4, 1 and 1.
- R2: With no slip request, the sample counter steps by one each clock from 0 to sym_len-1 and then returns to 0. The symbol strobe is high for exactly the one cycle in which the counter shows the last sample, so a symbol lasts sym_len cycles.
- R3: The symbol counter advances on every symbol strobe and wraps to 0 after sf_len-1. The superframe strobe is high only together with the symbol strobe, and only when the symbol counter shows sf_len-1.
- R4: The sync counter advances on every superframe strobe and wraps to 0 after hf_len-1. The hyperframe strobe is high only together with the superframe strobe, and only when the sync counter shows hf_len-1.
- R5: An accepted insert request makes the current symbol sym_len+1 cycles long, with the sample counter reaching the value sym_len.
- R6: An accepted delete request makes the current symbol sym_len-1 cycles long. A delete requested in the cycle where the counter shows sym_len-3 is still accepted.
- R7: A slip affects only the symbol in which it is accepted. The symbol after it has the nominal length again.
- R8: After one request has been accepted in a symbol, every further insert or delete request in that symbol is ignored.
- R9: A request is accepted only in a cycle where the sample counter is below sym_len-2. Requests in later cycles are dropped, not deferred. A cycle in which insert and delete are both high is ignored.
- R10: When load is high at a clock edge, the counters show ld_smp, ld_sym and ld_sync in the next cycle. Load overrides any wrap and any slip request in that cycle, and it discards a slip already accepted in the current symbol. The loaded values must be below their limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_len_i | input | SMP_W | Samples per symbol, including the prefix |
| sf_len_i | input | SYM_W | Symbols per superframe |
| hf_len_i | input | SYNC_W | Superframes per hyperframe |
| slip_ins_i | input | 1 | Request to stretch the current symbol by one sample |
| slip_del_i | input | 1 | Request to shorten the current symbol by one sample |
| load_i | input | 1 | Synchronous load of all counters |
| ld_smp_i | input | SMP_W | Sample counter value applied by a load |
| ld_sym_i | input | SYM_W | Symbol counter value applied by a load |
| ld_sync_i | input | SYNC_W | Sync counter value applied by a load |
| smp_cnt_o | output | SMP_W | Current sample within the symbol |
| sym_cnt_o | output | SYM_W | Current symbol within the superframe |
| sync_cnt_o | output | SYNC_W | Current superframe within the hyperframe |
| sym_stb_o | output | 1 | High in the last sample of a symbol |
| sf_stb_o | output | 1 | High in the last sample of a superframe |
| hf_stb_o | output | 1 | High in the last sample of a hyperframe |

## Verification
The pair of functions that can meet in a single cycle is a load and a slip request. The bench first gets an insert accepted early in a symbol. It then raises load and delete together, so the load edge sees both a pending stretch and a fresh request. The load is judged correct if the partial symbol that follows runs from the loaded sample to the nominal end, with no extra and no missing sample. Its superframe and hyperframe strobes must also match the loaded symbol and sync positions. A second, quieter collision is a request in the final window before a wrap. There the length the scoreboard measures shows whether the request was dropped or carried into the next symbol.

// File: rtl/dtb_pkg.sv
`timescale 1ns/1ps
package dtb_pkg;

    // Nominal lengths: 512 data samples plus a 32-sample prefix per symbol
    localparam int unsigned NOM_SYM_LEN = 544;
    localparam int unsigned NOM_SF_LEN  = 68;
    localparam int unsigned NOM_HF_LEN  = 4;

    // Adjustment applied to the terminal count of the current symbol
    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_LONG  = 2'd1,
        ADJ_SHORT = 2'd2
    } adj_e;

    // Boundary strobes, innermost first
    typedef struct packed {
        logic sym;
        logic sf;
        logic hf;
    } edge_t;

    // Turn the two request lines into an adjustment; both high means none
    function automatic adj_e decode_req(input logic ins, input logic del);
        adj_e r;
        if (ins && !del)      r = ADJ_LONG;
        else if (del && !ins) r = ADJ_SHORT;
        else                  r = ADJ_NONE;
        return r;
    endfunction

endpackage

// File: rtl/dtb_sample_ctr.sv
`timescale 1ns/1ps
module dtb_sample_ctr
    import dtb_pkg::*;
#(
    parameter int unsigned W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] len_i,
    input  logic         ins_i,
    input  logic         del_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] last_val;
    adj_e         adj_q;
    adj_e         req;
    logic         window;

    // Terminal count of the current symbol, moved by an accepted slip
    always_comb begin
        case (adj_q)
            ADJ_LONG:  last_val = len_i;
            ADJ_SHORT: last_val = len_i - W'(2);
            default:   last_val = len_i - W'(1);
        endcase
    end

    assign last_o = (cnt_q == last_val);
    assign window = (cnt_q < (len_i - W'(2)));
    assign req    = decode_req(ins_i, del_i);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            adj_q <= ADJ_NONE;
        end else if (load_i) begin
            cnt_q <= load_val_i;
            adj_q <= ADJ_NONE;
        end else if (last_o) begin
            cnt_q <= '0;
            adj_q <= ADJ_NONE;
        end else begin
            cnt_q <= cnt_q + W'(1);
            if (adj_q == ADJ_NONE && window)
                adj_q <= req;
        end
    end

    // R2: a symbol end without load restarts at sample zero
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (last_o && !load_i) |=> (cnt_q == '0));

    // R8: an accepted slip stays in force until the symbol ends
    p_adj_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (adj_q != ADJ_NONE && !last_o && !load_i) |=> (adj_q == $past(adj_q)));

    // R9: no request is taken in the closing samples of a symbol
    p_late_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (adj_q == ADJ_NONE && !last_o && !load_i && cnt_q >= (len_i - W'(2)))
        |=> (adj_q == ADJ_NONE));

endmodule

// File: rtl/dtb_wrap_ctr.sv
`timescale 1ns/1ps
module dtb_wrap_ctr #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv_i,
    input  logic [W-1:0] len_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);

    logic [W-1:0] cnt_q;

    assign last_o = (cnt_q == (len_i - W'(1)));
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (adv_i)
            cnt_q <= last_o ? '0 : cnt_q + W'(1);
    end

    // R3: the count wraps to zero after its last value
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (adv_i && last_o && !load_i) |=> (cnt_q == '0));

    // R3: without an advance or a load the count holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/dmt_symbol_timebase.sv
`timescale 1ns/1ps
module dmt_symbol_timebase
    import dtb_pkg::*;
#(
    parameter int unsigned SMP_W  = 11,
    parameter int unsigned SYM_W  = 7,
    parameter int unsigned SYNC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SMP_W-1:0]  sym_len_i,
    input  logic [SYM_W-1:0]  sf_len_i,
    input  logic [SYNC_W-1:0] hf_len_i,
    input  logic              slip_ins_i,
    input  logic              slip_del_i,
    input  logic              load_i,
    input  logic [SMP_W-1:0]  ld_smp_i,
    input  logic [SYM_W-1:0]  ld_sym_i,
    input  logic [SYNC_W-1:0] ld_sync_i,
    output logic [SMP_W-1:0]  smp_cnt_o,
    output logic [SYM_W-1:0]  sym_cnt_o,
    output logic [SYNC_W-1:0] sync_cnt_o,
    output logic              sym_stb_o,
    output logic              sf_stb_o,
    output logic              hf_stb_o
);

    edge_t stb;
    logic  smp_last;
    logic  sym_last;
    logic  sync_last;

    dtb_sample_ctr #(.W(SMP_W)) u_smp (
        .clk        (clk),
        .rst        (rst),
        .len_i      (sym_len_i),
        .ins_i      (slip_ins_i),
        .del_i      (slip_del_i),
        .load_i     (load_i),
        .load_val_i (ld_smp_i),
        .cnt_o      (smp_cnt_o),
        .last_o     (smp_last)
    );

    dtb_wrap_ctr #(.W(SYM_W)) u_sym (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (stb.sym),
        .len_i      (sf_len_i),
        .load_i     (load_i),
        .load_val_i (ld_sym_i),
        .cnt_o      (sym_cnt_o),
        .last_o     (sym_last)
    );

    dtb_wrap_ctr #(.W(SYNC_W)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (stb.sf),
        .len_i      (hf_len_i),
        .load_i     (load_i),
        .load_val_i (ld_sync_i),
        .cnt_o      (sync_cnt_o),
        .last_o     (sync_last)
    );

    // Outer boundaries are qualified by the inner ones
    always_comb begin
        stb.sym = smp_last;
        stb.sf  = smp_last && sym_last;
        stb.hf  = smp_last && sym_last && sync_last;
    end

    assign sym_stb_o = stb.sym;
    assign sf_stb_o  = stb.sf;
    assign hf_stb_o  = stb.hf;

    // R3: superframe boundary only on a symbol boundary
    p_sf_on_sym_r3: assert property (@(posedge clk) disable iff (rst)
        sf_stb_o |-> sym_stb_o);

    // R4: hyperframe boundary only on a superframe boundary
    p_hf_on_sf_r4: assert property (@(posedge clk) disable iff (rst)
        hf_stb_o |-> sf_stb_o);

    // R3: a symbol boundary inside a superframe advances the symbol count
    p_sym_step_r3: assert property (@(posedge clk) disable iff (rst)
        (sym_stb_o && !sf_stb_o && !load_i)
        |=> (sym_cnt_o == $past(sym_cnt_o) + SYM_W'(1)));

    // R10: a load lands in all three counters on the next cycle
    p_load_r10: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (smp_cnt_o == $past(ld_smp_i) &&
                    sym_cnt_o == $past(ld_sym_i) &&
                    sync_cnt_o == $past(ld_sync_i)));

endmodule

// File: tb/sim_dmt_symbol_timebase.sv
`timescale 1ns/1ps
module sim_dmt_symbol_timebase;

    localparam int SMP_W  = 11;
    localparam int SYM_W  = 7;
    localparam int SYNC_W = 8;
    localparam int L  = 20;
    localparam int SF = 3;
    localparam int HF = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [SMP_W-1:0]  sym_len = SMP_W'(L);
    logic [SYM_W-1:0]  sf_len  = SYM_W'(SF);
    logic [SYNC_W-1:0] hf_len  = SYNC_W'(HF);
    logic              slip_ins = 1'b0;
    logic              slip_del = 1'b0;
    logic              load = 1'b0;
    logic [SMP_W-1:0]  ld_smp = '0;
    logic [SYM_W-1:0]  ld_sym = '0;
    logic [SYNC_W-1:0] ld_sync = '0;
    logic [SMP_W-1:0]  smp_cnt;
    logic [SYM_W-1:0]  sym_cnt;
    logic [SYNC_W-1:0] sync_cnt;
    logic              sym_stb, sf_stb, hf_stb;

    always #2.5 clk = ~clk;

    dmt_symbol_timebase #(.SMP_W(SMP_W), .SYM_W(SYM_W), .SYNC_W(SYNC_W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .sym_len_i  (sym_len),
        .sf_len_i   (sf_len),
        .hf_len_i   (hf_len),
        .slip_ins_i (slip_ins),
        .slip_del_i (slip_del),
        .load_i     (load),
        .ld_smp_i   (ld_smp),
        .ld_sym_i   (ld_sym),
        .ld_sync_i  (ld_sync),
        .smp_cnt_o  (smp_cnt),
        .sym_cnt_o  (sym_cnt),
        .sync_cnt_o (sync_cnt),
        .sym_stb_o  (sym_stb),
        .sf_stb_o   (sf_stb),
        .hf_stb_o   (hf_stb)
    );

    typedef struct {
        int    len;
        int    sym;
        int    sync;
        bit    sf;
        bit    hf;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   n_chk = 0;
    int   n_err = 0;
    int   bsym = 0;
    int   run_len = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected shape of the next symbol
    task automatic push(input int len, input string tag);
        exp_t e;
        e.len  = len;
        e.sym  = bsym % SF;
        e.sync = (bsym / SF) % HF;
        e.sf   = (bsym % SF) == SF - 1;
        e.hf   = (bsym % (SF * HF)) == SF * HF - 1;
        e.tag  = tag;
        q.push_back(e);
        bsym++;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse(input bit ins, input bit del);
        slip_ins = ins;
        slip_del = del;
        step();
        slip_ins = 1'b0;
        slip_del = 1'b0;
    endtask

    // One symbol with up to two requests at given sample positions
    task automatic run_sym(input int len, input string tag,
                           input bit i1, input bit d1, input int at1,
                           input bit i2, input bit d2, input int at2);
        push(len, tag);
        step();
        if (i1 || d1) begin
            while (int'(smp_cnt) != at1) step();
            pulse(i1, d1);
        end
        if (i2 || d2) begin
            while (int'(smp_cnt) != at2) step();
            pulse(i2, d2);
        end
        while (!sym_stb) step();
    endtask

    // Monitor: measure each symbol and compare with the queue head
    always @(negedge clk) begin
        if (rst || !mon_en) begin
            run_len = 0;
        end else begin
            run_len++;
            if (sym_stb) begin
                if (q.size() == 0) begin
                    check_eq("R2", "symbol strobe with nothing expected", 1, 0);
                end else begin
                    cur = q.pop_front();
                    check_eq(cur.tag, "symbol length", run_len, cur.len);
                    check_eq("R3", "symbol index at boundary", int'(sym_cnt), cur.sym);
                    check_eq("R4", "sync index at boundary", int'(sync_cnt), cur.sync);
                    check_eq("R3", "superframe strobe", int'(sf_stb), int'(cur.sf));
                    check_eq("R4", "hyperframe strobe", int'(hf_stb), int'(cur.hf));
                end
                run_len = 0;
            end
        end
    end

    initial begin
        repeat (3) step();
        // R1: reset state
        check_eq("R1", "sample count in reset", int'(smp_cnt), 0);
        check_eq("R1", "symbol count in reset", int'(sym_cnt), 0);
        check_eq("R1", "sync count in reset", int'(sync_cnt), 0);
        check_eq("R1", "strobes in reset", int'({sym_stb, sf_stb, hf_stb}), 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        mon_en = 1'b1;

        run_sym(L,     "R2", 0, 0, 0,  0, 0, 0);
        run_sym(L + 1, "R5", 1, 0, 5,  0, 0, 0);
        run_sym(L,     "R7", 0, 0, 0,  0, 0, 0);
        run_sym(L - 1, "R6", 0, 1, 5,  0, 0, 0);
        run_sym(L + 1, "R8", 1, 0, 4,  0, 1, 8);
        run_sym(L - 1, "R6", 0, 1, L - 3, 0, 0, 0);
        run_sym(L,     "R9", 1, 0, L - 2, 0, 0, 0);
        run_sym(L,     "R9", 1, 1, 6,  0, 0, 0);

        // R10: insert accepted, then load together with a delete request
        step();
        while (int'(smp_cnt) != 2) step();
        pulse(1, 0);
        ld_smp  = SMP_W'(15);
        ld_sym  = SYM_W'(2);
        ld_sync = SYNC_W'(1);
        load = 1'b1;
        slip_del = 1'b1;
        mon_en = 1'b0;
        step();
        load = 1'b0;
        slip_del = 1'b0;
        check_eq("R10", "loaded sample count", int'(smp_cnt), 15);
        check_eq("R10", "loaded symbol count", int'(sym_cnt), 2);
        check_eq("R10", "loaded sync count", int'(sync_cnt), 1);
        bsym = 5;
        push(L - 16, "R10");
        mon_en = 1'b1;
        while (!sym_stb) step();

        run_sym(L,     "R3", 0, 0, 0, 0, 0, 0);
        run_sym(L + 1, "R5", 1, 0, 0, 0, 0, 0);
        run_sym(L,     "R7", 0, 0, 0, 0, 0, 0);

        repeat (3) step();
        check_eq("R2", "expected symbols left over", q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule